// File: doc/BRIEF.md
# Processor Operating Mode Decoder

This block turns a handful of architectural control bits into one precomputed status word. The word holds the execution mode, the submode, the current privilege level, the paging and protection flags, the default and alternate operand sizes, the default and alternate address sizes, and the stack size. Downstream logic reads the fields straight from the word and never has to decode the control bits again.

The inputs are sampled when an update strobe is high. The word is registered and does not change between strobes. A controller raises the strobe each time a control register or a segment attribute changes. The decoder then has the new word ready on the next cycle.

Top module: `opmode_decoder`

## Requirements
- R1: When long mode is active (`lma_i`=1), mode is long (1). Submode is 64-bit (0) if the code segment long bit is set, and compatibility (1) otherwise.
- R2: When long mode is inactive, mode is legacy (0). Submode is virtual-8086 (3) when protection is on and the VM flag is set, protected (2) when protection is on and VM is clear, and real (4) when protection is off. The VM flag is ignored in real submode.
- R3: The privilege level output copies the code segment privilege field. The paging and protection outputs copy the paging-enable and protection-enable inputs.
- R4: Sizes use the codes 1=16-bit, 2=32-bit, 3=64-bit. Operand size is default 2 / alternate 1 in 64-bit submode or when the code segment default-size bit is set, and default 1 / alternate 2 otherwise.
- R5: Address size is default 3 / alternate 2 in 64-bit submode, default 2 / alternate 1 when the code segment default-size bit is set, and default 1 / alternate 2 otherwise.
- R6: Stack size is 3 in 64-bit submode, 2 when the stack segment default-size bit is set, and 1 otherwise.
- R7: All outputs take new values on the clock edge after a cycle with `update_i`=1. They hold their values while `update_i`=0, whatever the other inputs do.
- R8: After reset the outputs show legacy mode, real submode, privilege 0, paging and protection off, and every size field equal to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| update_i | input | 1 | Strobe: recompute the word from the inputs |
| lma_i | input | 1 | Long mode active |
| pe_i | input | 1 | Protection enable |
| pg_i | input | 1 | Paging enable |
| vm_i | input | 1 | Virtual-8086 flag |
| cs_long_i | input | 1 | Code segment long bit |
| cs_dsize_i | input | 1 | Code segment default-size bit |
| cs_dpl_i | input | 2 | Code segment privilege field |
| ss_dsize_i | input | 1 | Stack segment default-size bit |
| mode_o | output | 1 | 0 legacy, 1 long |
| submode_o | output | 3 | Submode code |
| cpl_o | output | 2 | Current privilege level |
| paging_o | output | 1 | Paging flag |
| prot_o | output | 1 | Protection flag |
| def_op_o | output | 2 | Default operand size code |
| alt_op_o | output | 2 | Alternate operand size code |
| def_addr_o | output | 2 | Default address size code |
| alt_addr_o | output | 2 | Alternate address size code |
| stack_o | output | 2 | Stack size code |

## Verification
A wrong submode shows up in the size fields as well. A 64-bit submode reported in legacy mode, for example, forces the address size to 3 and the stack size to 3. Every field is registered once, so any wrong internal decision appears at the ports on the cycle after the strobe. If the hold logic is wrong, the word changes while no strobe is applied, and this is seen in the first cycle in which the inputs change without a strobe.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
  localparam int SZW = 2;
  localparam int SMW = 3;

  typedef enum logic [0:0] {MODE_LEGACY = 1'b0, MODE_LONG = 1'b1} mode_e;
  typedef enum logic [SMW-1:0] {
    SUB_64 = 3'd0, SUB_COMPAT = 3'd1, SUB_PROT = 3'd2,
    SUB_V86 = 3'd3, SUB_REAL = 3'd4
  } submode_e;

  localparam logic [SZW-1:0] SZ16 = 2'd1;
  localparam logic [SZW-1:0] SZ32 = 2'd2;
  localparam logic [SZW-1:0] SZ64 = 2'd3;

  typedef struct packed {
    mode_e          mode;
    submode_e       submode;
    logic [1:0]     cpl;
    logic           paging;
    logic           prot;
    logic [SZW-1:0] def_op;
    logic [SZW-1:0] alt_op;
    logic [SZW-1:0] def_addr;
    logic [SZW-1:0] alt_addr;
    logic [SZW-1:0] stack;
  } status_t;

  function automatic submode_e pick_submode(logic lma, logic cs_long, logic pe, logic vm);
    if (lma) return cs_long ? SUB_64 : SUB_COMPAT;
    if (!pe) return SUB_REAL;
    return vm ? SUB_V86 : SUB_PROT;
  endfunction

  function automatic status_t reset_word();
    status_t w;
    w.mode = MODE_LEGACY; w.submode = SUB_REAL; w.cpl = 2'd0;
    w.paging = 1'b0; w.prot = 1'b0;
    w.def_op = SZ16; w.alt_op = SZ16; w.def_addr = SZ16;
    w.alt_addr = SZ16; w.stack = SZ16;
    return w;
  endfunction
endpackage

// File: rtl/opmode_submode.sv
module opmode_submode
  import opmode_pkg::*;
(
  input  logic     lma_i,
  input  logic     pe_i,
  input  logic     vm_i,
  input  logic     cs_long_i,
  output mode_e    mode_o,
  output submode_e submode_o,
  output logic     is64_o
);
  always_comb begin
    mode_o    = lma_i ? MODE_LONG : MODE_LEGACY;
    submode_o = pick_submode(lma_i, cs_long_i, pe_i, vm_i);
    is64_o    = (submode_o == SUB_64);
  end
endmodule

// File: rtl/opmode_sizes.sv
module opmode_sizes
  import opmode_pkg::*;
(
  input  logic           is64_i,
  input  logic           cs_dsize_i,
  input  logic           ss_dsize_i,
  output logic [SZW-1:0] def_op_o,
  output logic [SZW-1:0] alt_op_o,
  output logic [SZW-1:0] def_addr_o,
  output logic [SZW-1:0] alt_addr_o,
  output logic [SZW-1:0] stack_o
);
  always_comb begin
    if (is64_i || cs_dsize_i) begin
      def_op_o = SZ32; alt_op_o = SZ16;
    end else begin
      def_op_o = SZ16; alt_op_o = SZ32;
    end
    if (is64_i) begin
      def_addr_o = SZ64; alt_addr_o = SZ32;
    end else if (cs_dsize_i) begin
      def_addr_o = SZ32; alt_addr_o = SZ16;
    end else begin
      def_addr_o = SZ16; alt_addr_o = SZ32;
    end
    if (is64_i)          stack_o = SZ64;
    else if (ss_dsize_i) stack_o = SZ32;
    else                 stack_o = SZ16;
  end
endmodule

// File: rtl/opmode_decoder.sv
module opmode_decoder
  import opmode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       update_i,
  input  logic       lma_i,
  input  logic       pe_i,
  input  logic       pg_i,
  input  logic       vm_i,
  input  logic       cs_long_i,
  input  logic       cs_dsize_i,
  input  logic [1:0] cs_dpl_i,
  input  logic       ss_dsize_i,
  output logic       mode_o,
  output logic [2:0] submode_o,
  output logic [1:0] cpl_o,
  output logic       paging_o,
  output logic       prot_o,
  output logic [1:0] def_op_o,
  output logic [1:0] alt_op_o,
  output logic [1:0] def_addr_o,
  output logic [1:0] alt_addr_o,
  output logic [1:0] stack_o
);
  mode_e    nxt_mode;
  submode_e nxt_sub;
  logic     nxt_is64;
  status_t  nxt_word, word_q;

  opmode_submode u_sub (
    .lma_i(lma_i), .pe_i(pe_i), .vm_i(vm_i), .cs_long_i(cs_long_i),
    .mode_o(nxt_mode), .submode_o(nxt_sub), .is64_o(nxt_is64)
  );

  logic [SZW-1:0] n_dop, n_aop, n_dad, n_aad, n_stk;
  opmode_sizes u_sz (
    .is64_i(nxt_is64), .cs_dsize_i(cs_dsize_i), .ss_dsize_i(ss_dsize_i),
    .def_op_o(n_dop), .alt_op_o(n_aop), .def_addr_o(n_dad),
    .alt_addr_o(n_aad), .stack_o(n_stk)
  );

  always_comb begin
    nxt_word.mode     = nxt_mode;
    nxt_word.submode  = nxt_sub;
    nxt_word.cpl      = cs_dpl_i;
    nxt_word.paging   = pg_i;
    nxt_word.prot     = pe_i;
    nxt_word.def_op   = n_dop;
    nxt_word.alt_op   = n_aop;
    nxt_word.def_addr = n_dad;
    nxt_word.alt_addr = n_aad;
    nxt_word.stack    = n_stk;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       word_q <= reset_word();
    else if (update_i) word_q <= nxt_word;
  end

  assign mode_o     = word_q.mode;
  assign submode_o  = word_q.submode;
  assign cpl_o      = word_q.cpl;
  assign paging_o   = word_q.paging;
  assign prot_o     = word_q.prot;
  assign def_op_o   = word_q.def_op;
  assign alt_op_o   = word_q.alt_op;
  assign def_addr_o = word_q.def_addr;
  assign alt_addr_o = word_q.alt_addr;
  assign stack_o    = word_q.stack;

  logic in_reset_q;
  always_ff @(posedge clk_i) in_reset_q <= !rst_ni;

  assert_long_mode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && lma_i |=> mode_o && (submode_o == 3'd0 || submode_o == 3'd1));
  assert_legacy_sub_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && !lma_i |=> !mode_o && submode_o >= 3'd2 && submode_o <= 3'd4);
  assert_mirror_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> cpl_o == $past(cs_dpl_i) && paging_o == $past(pg_i) && prot_o == $past(pe_i));
  assert_op_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> def_op_o != alt_op_o && def_op_o != 2'd3);
  assert_addr64_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (def_addr_o == 2'd3) |-> submode_o == 3'd0 && alt_addr_o == 2'd2);
  assert_stack64_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (submode_o == 3'd0) == (stack_o == 2'd3));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i && !in_reset_q |=> $stable(word_q));
  assert_reset_R8: assert property (@(posedge clk_i)
    in_reset_q && rst_ni |-> submode_o == 3'd4 && stack_o == 2'd1 && def_op_o == 2'd1);
endmodule

// File: tb/opmode_decoder_bench.sv
module opmode_decoder_bench;
  logic clk = 0, rst_n = 0, upd = 0;
  logic lma = 0, pe = 0, pg = 0, vm = 0, csl = 0, csd = 0, ssd = 0;
  logic [1:0] dpl = 0;
  logic mode, paging, prot;
  logic [2:0] sub;
  logic [1:0] cpl, dop, aop, dad, aad, stk;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  opmode_decoder u_opmode_decoder (
    .clk_i(clk), .rst_ni(rst_n), .update_i(upd), .lma_i(lma), .pe_i(pe),
    .pg_i(pg), .vm_i(vm), .cs_long_i(csl), .cs_dsize_i(csd), .cs_dpl_i(dpl),
    .ss_dsize_i(ssd), .mode_o(mode), .submode_o(sub), .cpl_o(cpl),
    .paging_o(paging), .prot_o(prot), .def_op_o(dop), .alt_op_o(aop),
    .def_addr_o(dad), .alt_addr_o(aad), .stack_o(stk)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(logic a, logic p, logic g, logic v, logic l, logic d,
                       logic s, logic [1:0] pl);
    @(negedge clk);
    lma = a; pe = p; pg = g; vm = v; csl = l; csd = d; ssd = s; dpl = pl;
    upd = 1;
    @(negedge clk);
    upd = 0;
  endtask

  // Compute the expected word from the requirements and compare it.
  task automatic expect_word(string tag);
    int esub, edo, eao, eda, eaa, est;
    if (lma) esub = csl ? 0 : 1;
    else if (!pe) esub = 4;
    else esub = vm ? 3 : 2;
    if (esub == 0 || csd) begin edo = 2; eao = 1; end else begin edo = 1; eao = 2; end
    if (esub == 0) begin eda = 3; eaa = 2; end
    else if (csd) begin eda = 2; eaa = 1; end
    else begin eda = 1; eaa = 2; end
    est = (esub == 0) ? 3 : (ssd ? 2 : 1);
    chk({tag, " R1/mode"}, mode, lma);
    chk({tag, " R2 submode"}, sub, esub);
    chk({tag, " R3 cpl"}, cpl, dpl);
    chk({tag, " R3 paging"}, paging, pg);
    chk({tag, " R3 prot"}, prot, pe);
    chk({tag, " R4 def_op"}, dop, edo);
    chk({tag, " R4 alt_op"}, aop, eao);
    chk({tag, " R5 def_addr"}, dad, eda);
    chk({tag, " R5 alt_addr"}, aad, eaa);
    chk({tag, " R6 stack"}, stk, est);
  endtask

  task automatic t_reset();
    chk("R8 mode", mode, 0); chk("R8 sub", sub, 4); chk("R8 cpl", cpl, 0);
    chk("R8 paging", paging, 0); chk("R8 prot", prot, 0);
    chk("R8 dop", dop, 1); chk("R8 aop", aop, 1); chk("R8 dad", dad, 1);
    chk("R8 aad", aad, 1); chk("R8 stk", stk, 1);
  endtask

  task automatic t_long();
    apply(1, 1, 1, 0, 1, 0, 0, 2'd0); expect_word("R1 64bit");
    apply(1, 1, 1, 0, 1, 1, 1, 2'd3); expect_word("R5 64bit csd");
    apply(1, 1, 1, 0, 0, 1, 0, 2'd3); expect_word("R1 compat32");
    apply(1, 1, 1, 1, 0, 0, 1, 2'd1); expect_word("R6 compat16");
  endtask

  task automatic t_legacy();
    apply(0, 0, 0, 1, 1, 0, 0, 2'd0); expect_word("R2 real vm ignored");
    apply(0, 1, 0, 0, 1, 1, 1, 2'd2); expect_word("R2 prot csl ignored");
    apply(0, 1, 1, 1, 0, 0, 0, 2'd3); expect_word("R2 v86");
    apply(0, 1, 1, 0, 0, 1, 0, 2'd1); expect_word("R4 prot32");
  endtask

  task automatic t_hold();
    int s0, st0, c0;
    apply(1, 1, 1, 0, 1, 0, 0, 2'd0);
    s0 = sub; st0 = stk; c0 = cpl;
    @(negedge clk);
    lma = 0; pe = 0; csl = 0; ssd = 1; dpl = 2'd3;
    repeat (3) @(negedge clk);
    chk("R7 hold sub", sub, s0); chk("R7 hold stk", stk, st0); chk("R7 hold cpl", cpl, c0);
    upd = 1; @(posedge clk); #1;
    chk("R7 one-cycle latency sub", sub, 4);
    @(negedge clk); upd = 0;
    expect_word("R7 after strobe");
  endtask

  initial begin
    fork
      begin : watchdog
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_long();
    t_legacy();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule